// File: doc/BRIEF.md
# Keyed Indexed Configuration Register Port

This block is the device end of an 8-bit legacy I/O configuration path. It answers at one of four candidate base addresses, picked by a two-bit strap. Its register file is hidden until software writes a key byte to the base port. While the key is in place, the index port at base+4 selects a register and the data port at base+8 reads or writes it. Any other byte written to the base port hides the registers again.

The register file holds 256 bytes with fixed power-on values. It includes an identification nibble in register 0x00 and four timing bytes for each of four drives. The sixteen timing bytes are presented in parallel to the drive-side timing logic, which lives outside this block. Reads are combinational. A read in the same cycle as a write returns the state from before that write.

Top module: `cfg_index_port`

## Requirements
- R1: The strap `base_sel` picks the base address: 0 gives 0x074, 1 gives 0x0F4, 2 gives 0x034 and 3 gives 0x0E4. The three bases that are not selected do not respond, and reads of them return 0xFF.
- R2: After reset the registers are hidden, the base port reads 0x00, and the index and data ports read 0xFF.
- R3: Writing the parameter `KEY` (0x30 to 0x33, default 0x30) to the base port exposes the registers. A later read of the base port returns `KEY`.
- R4: Writing any byte other than `KEY` to the base port hides the registers. A later read of the base port returns that byte.
- R5: While the registers are hidden, writes to the index and data ports have no effect, and reads of those ports return 0xFF.
- R6: While the registers are exposed, the index port at base+4 stores the byte written to it and returns that byte on reads.
- R7: While the registers are exposed, the data port at base+8 reads and writes the register chosen by the index. All eight bits are writable in every register except 0x00.
- R8: Register 0x00 always reads 0x5 in bits 7:4. Bits 3:0 are writable and reset to 0.
- R9: Reset values: register 0x01 = 0x0F, 0x07 = 0x2B, 0x0A = 0x0F, 0x34 = 0xFF, 0x35 = 0x03. Every other register resets to 0x00.
- R10: `drive_timing[(4*d+k)*8 +: 8]` carries timing byte k of drive d, taken from these registers (k = 0..3):
  - drive 0: 0x03, 0x26, 0x04, 0x27
  - drive 1: 0x05, 0x28, 0x06, 0x29
  - drive 2: 0x2B, 0x30, 0x2C, 0x31
  - drive 3: 0x2D, 0x32, 0x2E, 0x33
- R11: When a read and a write hit the same port in the same cycle, the read returns the value from before the write. The write takes effect at that clock edge.
- R12: `rdata` is 0xFF whenever `rd_en` is low or the address matches none of the three ports. Writes to unmatched addresses, such as base+1, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_sel | input | 2 | Strap that picks the base address |
| addr | input | 10 | I/O address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| drive_timing | output | 128 | Sixteen timing bytes, four per drive |

## Verification
Two functions can fall in the same cycle: a read and a write to the same port. The bench asserts `rd_en` and `wr_en` together, first on the index port and then on the data port. It expects the value from before the write during that cycle, and the new value on a separate read afterwards. The same rule applies when the base port hides the registers: a read made after the locking write must already see 0xFF from the data port.

// File: rtl/cfg_port_pkg.sv
// Package: shared constants and lookup functions for the keyed configuration port.
// Assumes an 8-bit data path and a 256-entry register space.
package cfg_port_pkg;

    localparam int DATA_W         = 8;
    localparam int NUM_DRIVES     = 4;
    localparam int REGS_PER_DRIVE = 4;
    localparam int NUM_TIMING     = NUM_DRIVES * REGS_PER_DRIVE;
    localparam int REG_DEPTH      = 2 ** DATA_W;
    localparam logic [3:0] ID_NIBBLE = 4'h5;

    // Candidate base address for each strap value.
    function automatic logic [11:0] base_of(input logic [1:0] sel);
        case (sel)
            2'd0:    base_of = 12'h074;
            2'd1:    base_of = 12'h0F4;
            2'd2:    base_of = 12'h034;
            default: base_of = 12'h0E4;
        endcase
    endfunction

    // Register index that holds timing byte k of drive d (slot = d*4 + k).
    function automatic logic [DATA_W-1:0] timing_reg(input int slot);
        case (slot)
            0:       timing_reg = 8'h03;
            1:       timing_reg = 8'h26;
            2:       timing_reg = 8'h04;
            3:       timing_reg = 8'h27;
            4:       timing_reg = 8'h05;
            5:       timing_reg = 8'h28;
            6:       timing_reg = 8'h06;
            7:       timing_reg = 8'h29;
            8:       timing_reg = 8'h2B;
            9:       timing_reg = 8'h30;
            10:      timing_reg = 8'h2C;
            11:      timing_reg = 8'h31;
            12:      timing_reg = 8'h2D;
            13:      timing_reg = 8'h32;
            14:      timing_reg = 8'h2E;
            default: timing_reg = 8'h33;
        endcase
    endfunction

    // Power-on value of a register.
    function automatic logic [DATA_W-1:0] reset_val(input logic [DATA_W-1:0] idx);
        case (idx)
            8'h01:   reset_val = 8'h0F;
            8'h07:   reset_val = 8'h2B;
            8'h0A:   reset_val = 8'h0F;
            8'h34:   reset_val = 8'hFF;
            8'h35:   reset_val = 8'h03;
            default: reset_val = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
// Address decoder: compares the bus address with the strapped base and with
// the index and data offsets from it.
// Assumes the strap is static during normal operation; the decode is purely
// combinational, so a strap change takes effect at once.
module cfg_addr_decode #(
    parameter int ADDR_W    = 10,
    parameter int IDX_OFFS  = 4,
    parameter int DATA_OFFS = 8
) (
    input  logic [1:0]        base_sel,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_base,
    output logic              hit_idx,
    output logic              hit_data
);
    import cfg_port_pkg::*;

    localparam logic [ADDR_W-1:0] IDX_OFS_V  = ADDR_W'(IDX_OFFS);
    localparam logic [ADDR_W-1:0] DATA_OFS_V = ADDR_W'(DATA_OFFS);

    logic [ADDR_W-1:0] base_addr;

    // Select the base for the current strap and match the three ports.
    always_comb begin
        base_addr = ADDR_W'(base_of(base_sel));
        hit_base  = (addr == base_addr);
        hit_idx   = (addr == base_addr + IDX_OFS_V);
        hit_data  = (addr == base_addr + DATA_OFS_V);
    end
endmodule

// File: rtl/cfg_ctrl.sv
// Access control: stores the last byte written to the base port, derives the
// exposed/hidden state from it, and holds the index latch.
// Assumes one write strobe per cycle; index writes count only while exposed.
module cfg_ctrl #(
    parameter int          DW  = 8,
    parameter logic [7:0]  KEY = 8'h30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_we,
    input  logic          idx_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] base_val,
    output logic          unlocked,
    output logic [DW-1:0] index_q
);
    // Base port byte and lock state; the key opens access and any other byte closes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_val <= '0;
            unlocked <= 1'b0;
        end else if (base_we) begin
            base_val <= wdata;
            unlocked <= (wdata == DW'(KEY));
        end
    end

    // Index latch; it loads only while access is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= '0;
        end else if (idx_we && unlocked) begin
            index_q <= wdata;
        end
    end
endmodule

// File: rtl/cfg_regfile.sv
// Configuration register file: 256 bytes with computed reset values, a fixed
// identification nibble in register 0, and parallel taps for the drive timing bytes.
// Assumes the caller gates the write enable with the access state.
module cfg_regfile #(
    parameter int DW    = 8,
    parameter int DEPTH = 256,
    parameter int NT    = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [DW-1:0]   idx,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic [NT*DW-1:0] timing
);
    import cfg_port_pkg::*;

    logic [DW-1:0] mem [DEPTH];

    // Storage: load reset values on reset, otherwise take the data-port write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= reset_val(DW'(i));
            end
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    // Read path; register 0 carries the identification nibble on top.
    always_comb begin
        if (idx == '0) begin
            rdata = {ID_NIBBLE, mem[0][3:0]};
        end else begin
            rdata = mem[idx];
        end
    end

    // One tap per timing byte, placed by drive and byte number.
    for (genvar s = 0; s < NT; s++) begin : g_tap
        assign timing[s*DW +: DW] = mem[timing_reg(s)];
    end
endmodule

// File: rtl/cfg_index_port.sv
// Top: keyed indexed configuration port on an 8-bit I/O bus.
// Combines the decoder, the access control and the register file, and muxes
// read data. Reads are combinational and show state from before any write
// made in the same cycle. Idle or unmatched reads return 0xFF.
module cfg_index_port #(
    parameter int         ADDR_W    = 10,
    parameter logic [7:0] KEY       = 8'h30,
    parameter int         IDX_OFFS  = 4,
    parameter int         DATA_OFFS = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   base_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [7:0]   wdata,
    output logic [7:0]   rdata,
    output logic [127:0] drive_timing
);
    import cfg_port_pkg::*;

    localparam logic [DATA_W-1:0] IDLE_BYTE = '1;

    logic              hit_base, hit_idx, hit_data;
    logic              unlocked;
    logic [DATA_W-1:0] base_val, index_q, reg_rdata;

    cfg_addr_decode #(
        .ADDR_W(ADDR_W), .IDX_OFFS(IDX_OFFS), .DATA_OFFS(DATA_OFFS)
    ) u_dec (
        .base_sel(base_sel), .addr(addr),
        .hit_base(hit_base), .hit_idx(hit_idx), .hit_data(hit_data)
    );

    cfg_ctrl #(.DW(DATA_W), .KEY(KEY)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .base_we(wr_en && hit_base), .idx_we(wr_en && hit_idx),
        .wdata(wdata), .base_val(base_val), .unlocked(unlocked), .index_q(index_q)
    );

    cfg_regfile #(.DW(DATA_W), .DEPTH(REG_DEPTH), .NT(NUM_TIMING)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en && hit_data && unlocked), .idx(index_q), .wdata(wdata),
        .rdata(reg_rdata), .timing(drive_timing)
    );

    // Read mux: base port always visible; index and data ports only while exposed.
    always_comb begin
        rdata = IDLE_BYTE;
        if (rd_en) begin
            if (hit_base) begin
                rdata = base_val;
            end else if (hit_idx && unlocked) begin
                rdata = index_q;
            end else if (hit_data && unlocked) begin
                rdata = reg_rdata;
            end
        end
    end
endmodule

// File: rtl/cfg_index_port_chk.sv
// Checker for cfg_index_port: properties on lock state, the index latch and read data.
module cfg_index_port_chk #(
    parameter logic [7:0] KEY = 8'h30
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       hit_base,
    input logic       hit_idx,
    input logic       hit_data,
    input logic       unlocked,
    input logic [7:0] base_val,
    input logic [7:0] index_q
);
    // R3
    key_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_base && wdata == KEY) |=> (unlocked && base_val == KEY));

    // R4
    other_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_base && wdata != KEY) |=> (!unlocked && base_val == $past(wdata)));

    // R5
    locked_idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_idx && !unlocked) |=> $stable(index_q));

    // R5
    locked_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (hit_idx || hit_data) && !unlocked) |-> rdata == 8'hFF);

    // R6
    idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_idx && unlocked) |=> index_q == $past(wdata));

    // R8
    id_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit_data && unlocked && index_q == 8'h00) |-> rdata[7:4] == 4'h5);

    // R12
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rdata == 8'hFF);
endmodule

bind cfg_index_port cfg_index_port_chk #(.KEY(KEY)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .hit_base(hit_base), .hit_idx(hit_idx), .hit_data(hit_data),
    .unlocked(unlocked), .base_val(base_val), .index_q(index_q)
);

// File: tb/cfg_index_port_tb_top.sv
module cfg_index_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 26;

    // Vector: {is_write, addr[9:0], data_or_expected[7:0], requirement[3:0]}
    localparam logic [22:0] VEC [NVEC] = '{
        {1'b0, 10'h074, 8'h00, 4'd2},  // R2 base port after reset
        {1'b0, 10'h078, 8'hFF, 4'd2},  // R2 index hidden
        {1'b0, 10'h07C, 8'hFF, 4'd2},  // R2 data hidden
        {1'b1, 10'h078, 8'h07, 4'd5},  // R5 locked index write
        {1'b1, 10'h074, 8'h30, 4'd3},  // R3 key
        {1'b0, 10'h074, 8'h30, 4'd3},  // R3 base echoes key
        {1'b0, 10'h078, 8'h00, 4'd5},  // R5 locked write was dropped
        {1'b1, 10'h078, 8'h07, 4'd6},
        {1'b0, 10'h078, 8'h07, 4'd6},  // R6 index readback
        {1'b0, 10'h07C, 8'h2B, 4'd9},  // R9 default of 0x07
        {1'b1, 10'h078, 8'h34, 4'd9},
        {1'b0, 10'h07C, 8'hFF, 4'd9},  // R9 default of 0x34
        {1'b1, 10'h078, 8'h00, 4'd8},
        {1'b0, 10'h07C, 8'h50, 4'd8},  // R8 id nibble at reset
        {1'b1, 10'h07C, 8'hA7, 4'd8},
        {1'b0, 10'h07C, 8'h57, 4'd8},  // R8 upper nibble fixed
        {1'b1, 10'h078, 8'h26, 4'd7},
        {1'b1, 10'h07C, 8'h5C, 4'd7},
        {1'b0, 10'h07C, 8'h5C, 4'd7},  // R7 data write/read
        {1'b1, 10'h074, 8'h12, 4'd4},  // R4 lock with other byte
        {1'b0, 10'h074, 8'h12, 4'd4},  // R4 base echoes it
        {1'b0, 10'h07C, 8'hFF, 4'd5},  // R5 data hidden again
        {1'b1, 10'h07C, 8'h99, 4'd5},  // R5 locked data write
        {1'b1, 10'h074, 8'h30, 4'd3},
        {1'b0, 10'h07C, 8'h5C, 4'd5},  // R5 register kept its value
        {1'b0, 10'h078, 8'h26, 4'd6}   // R6 index kept across lock
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   base_sel = 2'd0;
    logic [9:0]   addr = '0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [7:0]   wdata = '0;
    logic [7:0]   rdata;
    logic [127:0] drive_timing;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_index_port dut_i (
        .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .drive_timing(drive_timing)
    );

    function automatic logic [9:0] bench_base(input int s);
        case (s)
            0: bench_base = 10'h074;
            1: bench_base = 10'h0F4;
            2: bench_base = 10'h034;
            default: bench_base = 10'h0E4;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [9:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 check(req, rdata, exp);
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R2 idle bus and default timing outputs
        #1 check("R12 idle read", rdata, 8'hFF);
        check("R10 default timing", drive_timing[7:0], 8'h00);

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[v][3:0], v);
            if (VEC[v][22]) bus_wr(VEC[v][21:12], VEC[v][11:4]);
            else            bus_rd(VEC[v][21:12], VEC[v][11:4], tag);
        end

        // R10: timing taps for drive 2 and drive 0 byte 0
        bus_wr(10'h078, 8'h2B); bus_wr(10'h07C, 8'h11);
        bus_wr(10'h078, 8'h30); bus_wr(10'h07C, 8'h22);
        bus_wr(10'h078, 8'h2C); bus_wr(10'h07C, 8'h33);
        bus_wr(10'h078, 8'h31); bus_wr(10'h07C, 8'h44);
        bus_wr(10'h078, 8'h03); bus_wr(10'h07C, 8'h81);
        check("R10 drv2 b0", drive_timing[8*8 +: 8], 8'h11);
        check("R10 drv2 b1", drive_timing[9*8 +: 8], 8'h22);
        check("R10 drv2 b2", drive_timing[10*8 +: 8], 8'h33);
        check("R10 drv2 b3", drive_timing[11*8 +: 8], 8'h44);
        check("R10 drv0 b0", drive_timing[7:0], 8'h81);
        check("R10 drv0 b1", drive_timing[15:8], 8'h5C);

        // R11: read and write in the same cycle on the index port
        @(negedge clk);
        addr = 10'h078; wdata = 8'h2C; wr_en = 1'b1; rd_en = 1'b1;
        #1 check("R11 index same cycle", rdata, 8'h03);
        @(posedge clk); #1; wr_en = 1'b0; rd_en = 1'b0;
        bus_rd(10'h078, 8'h2C, "R11 index after");
        // R11: same on the data port
        @(negedge clk);
        addr = 10'h07C; wdata = 8'h3C; wr_en = 1'b1; rd_en = 1'b1;
        #1 check("R11 data same cycle", rdata, 8'h33);
        @(posedge clk); #1; wr_en = 1'b0; rd_en = 1'b0;
        bus_rd(10'h07C, 8'h3C, "R11 data after");

        // R12: unmatched address
        bus_wr(10'h075, 8'h55);
        bus_rd(10'h075, 8'hFF, "R12 unmatched read");
        bus_rd(10'h074, 8'h30, "R12 unmatched write ignored");

        // R1: each strap value
        for (int s = 0; s < 4; s++) begin
            base_sel = 2'(s);
            bus_rd(bench_base(s), 8'h30, $sformatf("R1 base sel%0d", s));
            bus_rd(bench_base(s) + 10'd4, 8'h2C, $sformatf("R1 index sel%0d", s));
            for (int j = 0; j < 4; j++) begin
                if (j != s) bus_rd(bench_base(j), 8'hFF, $sformatf("R1 other base %0d sel%0d", j, s));
            end
        end
        base_sel = 2'd2;
        bus_wr(10'h034, 8'h77);
        bus_rd(10'h03C, 8'hFF, "R4 lock at sel2");

        // R9: defaults after a fresh reset
        base_sel = 2'd0;
        do_reset();
        check("R9 timing cleared", drive_timing[8*8 +: 8], 8'h00);
        bus_wr(10'h074, 8'h30);
        bus_wr(10'h078, 8'h01); bus_rd(10'h07C, 8'h0F, "R9 reg01");
        bus_wr(10'h078, 8'h0A); bus_rd(10'h07C, 8'h0F, "R9 reg0A");
        bus_wr(10'h078, 8'h35); bus_rd(10'h07C, 8'h03, "R9 reg35");
        bus_wr(10'h078, 8'h26); bus_rd(10'h07C, 8'h00, "R9 reg26");

        finish_run();
    end
endmodule